// File: doc/BRIEF.md
# Register Window Occupancy Counters

This block keeps the three occupancy counts that a windowed register file needs to decide whether a call can open a new window or a return can reopen an old one. It tracks how many windows are free to be saved into, how many windows hold state that can be restored, and how many windows belong to a different context such as another process or privilege level. The window pointer, the registers themselves and any trap decisions live elsewhere and read these counts.

A spill handler pulses `spill_i` after writing a window out to memory, and a fill handler pulses `fill_i` after reading one back in. Each pulse frees or claims a window on the save side and moves a window on the other side. That second window is taken from the other-context pool while that pool is non-empty, and from the current context only once the pool is empty. Software can also load all three counts at once through a write strobe.

Top module: `winocc_counters`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the free count becomes NWINDOWS-2 and the restorable and other-context counts become zero.
- R2: A spill pulse (with no write) raises the free count by one.
- R3: A spill pulse with the other-context count at zero lowers the restorable count by one and leaves the other-context count at zero.
- R4: A spill pulse with a non-zero other-context count lowers the other-context count by one and leaves the restorable count unchanged.
- R5: A fill pulse (with no write and no spill) raises the restorable count by one.
- R6: A fill pulse with the other-context count at zero lowers the free count by one and leaves the other-context count at zero.
- R7: A fill pulse with a non-zero other-context count lowers the other-context count by one and leaves the free count unchanged.
- R8: When spill and fill pulse in the same cycle, only the spill is applied; the fill has no effect on any count.
- R9: A write strobe loads all three counts from the write data on the next edge, whatever the spill and fill inputs are.
- R10: With no spill, fill or write, all three counts hold their values.
- R11: Each count is W = ceil(log2(NWINDOWS)) bits wide, and increments and decrements wrap modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| spill_i | input | 1 | One-cycle pulse: a window was written out |
| fill_i | input | 1 | One-cycle pulse: a window was read back |
| wr_en_i | input | 1 | Load all three counts from the write data |
| wr_free_i | input | W | Value to load into the free count |
| wr_rest_i | input | W | Value to load into the restorable count |
| wr_other_i | input | W | Value to load into the other-context count |
| free_o | output | W | Windows free to save into |
| rest_o | output | W | Windows that can be restored |
| other_o | output | W | Windows owned by another context |

## Verification
The bench builds two copies side by side from one stimulus stream: NWINDOWS = 8, giving 3-bit counts with a reset free count of 6, and NWINDOWS = 4, giving 2-bit counts with a reset free count of 2. The narrow copy reaches the wrap boundary of R11 after only a few pulses, so random runs cross both the zero and the all-ones edges often. Both copies also switch often between empty and non-empty other-context pools, which drives both donor paths of R3/R4 and R6/R7.

// File: rtl/winocc_pkg.sv
// Shared types for the window occupancy counters.
// Assumes: one operation is applied per clock edge.
package winocc_pkg;

    // Operation applied to the counters on the next edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SPILL = 2'd1,
        OP_FILL  = 2'd2,
        OP_LOAD  = 2'd3
    } winocc_op_e;

endpackage

// File: rtl/winocc_arbiter.sv
// Picks the single operation for this cycle from the strobes.
// Priority: write load, then spill, then fill. Assumes strobes are
// clean single-bit levels sampled at the clock edge.
module winocc_arbiter
    import winocc_pkg::*;
(
    input  logic       spill_i,
    input  logic       fill_i,
    input  logic       wr_en_i,
    output winocc_op_e op_o
);

    // Fixed-priority encode of the three strobes.
    always_comb begin
        if (wr_en_i)      op_o = OP_LOAD;
        else if (spill_i) op_o = OP_SPILL;
        else if (fill_i)  op_o = OP_FILL;
        else              op_o = OP_HOLD;
    end

endmodule

// File: rtl/winocc_step.sv
// Computes the next counter values for one operation.
// The second window moved by a spill or fill is taken from the
// other-context pool while it is non-empty, otherwise from the
// current context. Arithmetic wraps at CW bits.
module winocc_step
    import winocc_pkg::*;
#(
    parameter int CW = 3
) (
    input  winocc_op_e       op_i,
    input  logic [CW-1:0]    free_i,
    input  logic [CW-1:0]    rest_i,
    input  logic [CW-1:0]    other_i,
    input  logic [CW-1:0]    wr_free_i,
    input  logic [CW-1:0]    wr_rest_i,
    input  logic [CW-1:0]    wr_other_i,
    output logic [CW-1:0]    free_o,
    output logic [CW-1:0]    rest_o,
    output logic [CW-1:0]    other_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic from_other;
    logic [CW-1:0] free_inc, free_dec, rest_inc, rest_dec, other_dec;

    // Donor choice: the other-context pool gives first.
    assign from_other = (other_i != '0);

    // Shared incrementers and decrementers, one per count.
    always_comb begin
        free_inc  = free_i + ONE;
        free_dec  = free_i - ONE;
        rest_inc  = rest_i + ONE;
        rest_dec  = rest_i - ONE;
        other_dec = other_i - ONE;
    end

    // Next-value selection per operation.
    always_comb begin
        free_o  = free_i;
        rest_o  = rest_i;
        other_o = other_i;
        unique case (op_i)
            OP_LOAD: begin
                free_o  = wr_free_i;
                rest_o  = wr_rest_i;
                other_o = wr_other_i;
            end
            OP_SPILL: begin
                free_o = free_inc;
                if (from_other) other_o = other_dec;
                else            rest_o  = rest_dec;
            end
            OP_FILL: begin
                rest_o = rest_inc;
                if (from_other) other_o = other_dec;
                else            free_o  = free_dec;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/winocc_regs.sv
// Holds the three counts. Synchronous active-low reset loads the
// free count with RST_FREE and clears the others.
module winocc_regs #(
    parameter int              CW       = 3,
    parameter logic [CW-1:0]   RST_FREE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   free_d,
    input  logic [CW-1:0]   rest_d,
    input  logic [CW-1:0]   other_d,
    output logic [CW-1:0]   free_q,
    output logic [CW-1:0]   rest_q,
    output logic [CW-1:0]   other_q
);

    // State update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q  <= RST_FREE;
            rest_q  <= '0;
            other_q <= '0;
        end else begin
            free_q  <= free_d;
            rest_q  <= rest_d;
            other_q <= other_d;
        end
    end

endmodule

// File: rtl/winocc_counters.sv
// Top of the window occupancy counters. Assumes NWINDOWS >= 3 and
// that spill and fill are single-cycle pulses from trap handlers.
module winocc_counters
    import winocc_pkg::*;
#(
    parameter int NWINDOWS = 8,
    localparam int CW      = $clog2(NWINDOWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spill_i,
    input  logic            fill_i,
    input  logic            wr_en_i,
    input  logic [CW-1:0]   wr_free_i,
    input  logic [CW-1:0]   wr_rest_i,
    input  logic [CW-1:0]   wr_other_i,
    output logic [CW-1:0]   free_o,
    output logic [CW-1:0]   rest_o,
    output logic [CW-1:0]   other_o
);

    localparam logic [CW-1:0] RST_FREE = CW'(NWINDOWS - 2);

    winocc_op_e    op;
    logic [CW-1:0] free_n, rest_n, other_n;

    winocc_arbiter u_arb (
        .spill_i (spill_i),
        .fill_i  (fill_i),
        .wr_en_i (wr_en_i),
        .op_o    (op)
    );

    winocc_step #(.CW(CW)) u_step (
        .op_i       (op),
        .free_i     (free_o),
        .rest_i     (rest_o),
        .other_i    (other_o),
        .wr_free_i  (wr_free_i),
        .wr_rest_i  (wr_rest_i),
        .wr_other_i (wr_other_i),
        .free_o     (free_n),
        .rest_o     (rest_n),
        .other_o    (other_n)
    );

    winocc_regs #(.CW(CW), .RST_FREE(RST_FREE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .free_d  (free_n),
        .rest_d  (rest_n),
        .other_d (other_n),
        .free_q  (free_o),
        .rest_q  (rest_o),
        .other_q (other_o)
    );

endmodule

// File: rtl/winocc_checker.sv
// Port-level properties of the window occupancy counters, bound to
// every instance of the top module.
module winocc_checker #(
    parameter int NWINDOWS = 8,
    parameter int CW       = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            spill_i,
    input logic            fill_i,
    input logic            wr_en_i,
    input logic [CW-1:0]   wr_free_i,
    input logic [CW-1:0]   wr_rest_i,
    input logic [CW-1:0]   wr_other_i,
    input logic [CW-1:0]   free_o,
    input logic [CW-1:0]   rest_o,
    input logic [CW-1:0]   other_o
);

    logic started = 1'b0;

    // Marks that at least one edge has passed.
    always_ff @(posedge clk) started <= 1'b1;

    a_r1_reset_values: assert property (@(posedge clk)
        (started && !$past(rst_n)) |->
            (free_o == CW'(NWINDOWS - 2) && rest_o == '0 && other_o == '0));

    a_r2_spill_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_i && !wr_en_i) |=> free_o == CW'($past(free_o) + 1'b1));

    a_r3_spill_own: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_i && !wr_en_i && other_o == '0) |=>
            (rest_o == CW'($past(rest_o) - 1'b1) && other_o == '0));

    a_r4_spill_other: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_i && !wr_en_i && other_o != '0) |=>
            (other_o == CW'($past(other_o) - 1'b1) && $stable(rest_o)));

    a_r5_fill_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !spill_i && !wr_en_i) |=> rest_o == CW'($past(rest_o) + 1'b1));

    a_r6_fill_own: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !spill_i && !wr_en_i && other_o == '0) |=>
            (free_o == CW'($past(free_o) - 1'b1) && other_o == '0));

    a_r7_fill_other: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !spill_i && !wr_en_i && other_o != '0) |=>
            (other_o == CW'($past(other_o) - 1'b1) && $stable(free_o)));

    a_r8_spill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && spill_i && !wr_en_i) |=> free_o == CW'($past(free_o) + 1'b1));

    a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (free_o == $past(wr_free_i) && rest_o == $past(wr_rest_i)
                     && other_o == $past(wr_other_i)));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!spill_i && !fill_i && !wr_en_i) |=>
            ($stable(free_o) && $stable(rest_o) && $stable(other_o)));

endmodule

bind winocc_counters winocc_checker #(.NWINDOWS(NWINDOWS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spill_i    (spill_i),
    .fill_i     (fill_i),
    .wr_en_i    (wr_en_i),
    .wr_free_i  (wr_free_i),
    .wr_rest_i  (wr_rest_i),
    .wr_other_i (wr_other_i),
    .free_o     (free_o),
    .rest_o     (rest_o),
    .other_o    (other_o)
);

// File: tb/winocc_counters_bench.sv
// Bench: two instances (NWINDOWS 8 and 4) driven by one stimulus
// stream, compared each cycle against a bench model.
module winocc_counters_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, spill, fill, wr_en;
    logic [2:0] wd_f, wd_r, wd_o;
    logic [2:0] a_free, a_rest, a_other;
    logic [1:0] b_free, b_rest, b_other;

    winocc_counters #(.NWINDOWS(8)) u_winocc_counters (
        .clk(clk), .rst_n(rst_n), .spill_i(spill), .fill_i(fill),
        .wr_en_i(wr_en), .wr_free_i(wd_f), .wr_rest_i(wd_r), .wr_other_i(wd_o),
        .free_o(a_free), .rest_o(a_rest), .other_o(a_other));

    winocc_counters #(.NWINDOWS(4)) u_winocc_counters_n4 (
        .clk(clk), .rst_n(rst_n), .spill_i(spill), .fill_i(fill),
        .wr_en_i(wr_en), .wr_free_i(wd_f[1:0]), .wr_rest_i(wd_r[1:0]),
        .wr_other_i(wd_o[1:0]),
        .free_o(b_free), .rest_o(b_rest), .other_o(b_other));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int ef[2], er[2], eo[2];
    int msk[2]  = '{7, 3};
    int nwin[2] = '{8, 4};

    // Model of reset values (R1).
    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            ef[k] = nwin[k] - 2; er[k] = 0; eo[k] = 0;
        end
    endtask

    // Model of one clock edge from the requirements.
    task automatic model_step(input bit s, input bit f, input bit w,
                              input int df, input int dr, input int dv);
        for (int k = 0; k < 2; k++) begin
            if (w) begin
                ef[k] = df & msk[k]; er[k] = dr & msk[k]; eo[k] = dv & msk[k];
            end else if (s) begin
                ef[k] = (ef[k] + 1) & msk[k];
                if (eo[k] != 0) eo[k] = eo[k] - 1;
                else            er[k] = (er[k] - 1) & msk[k];
            end else if (f) begin
                er[k] = (er[k] + 1) & msk[k];
                if (eo[k] != 0) eo[k] = eo[k] - 1;
                else            ef[k] = (ef[k] - 1) & msk[k];
            end
        end
    endtask

    function automatic int tag_of(bit s, bit f, bit w, int oth);
        if (w)             return 9;
        if (s && f)        return 8;
        if (s && oth != 0) return 4;
        if (s)             return 3;
        if (f && oth != 0) return 7;
        if (f)             return 6;
        return 10;
    endfunction

    // Compare both instances with the model.
    task automatic check(input string tag);
        checks++;
        if (a_free != ef[0] || a_rest != er[0] || a_other != eo[0]) begin
            fails++;
            $display("FAIL %s n8: got free=%0d rest=%0d other=%0d exp %0d %0d %0d",
                     tag, a_free, a_rest, a_other, ef[0], er[0], eo[0]);
        end
        checks++;
        if (b_free != ef[1] || b_rest != er[1] || b_other != eo[1]) begin
            fails++;
            $display("FAIL %s n4: got free=%0d rest=%0d other=%0d exp %0d %0d %0d",
                     tag, b_free, b_rest, b_other, ef[1], er[1], eo[1]);
        end
    endtask

    // Drive one operation for one edge, then check after the edge.
    task automatic op(input bit s, input bit f, input bit w,
                      input int df, input int dr, input int dv, input string tag);
        @(negedge clk);
        spill = s; fill = f; wr_en = w;
        wd_f = 3'(df); wd_r = 3'(dr); wd_o = 3'(dv);
        model_step(s, f, w, df, dr, dv);
        @(posedge clk);
        #1;
        spill = 0; fill = 0; wr_en = 0;
        check(tag);
    endtask

    initial begin
        int dummy;
        int t;
        bit s, f, w;
        dummy = $urandom(32'd2024);
        rst_n = 0; spill = 0; fill = 0; wr_en = 0; wd_f = 0; wd_r = 0; wd_o = 0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        check("R1 reset values");
        // R1: reset also wins over a pending spill.
        @(negedge clk); spill = 1;
        @(posedge clk); #1; spill = 0;
        check("R1 reset over spill");
        @(negedge clk); rst_n = 1;

        op(0, 0, 1, 2, 3, 0, "R9 load");
        op(1, 0, 0, 0, 0, 0, "R2/R3 spill own");
        op(0, 0, 1, 2, 3, 2, "R9 load other");
        op(1, 0, 0, 0, 0, 0, "R2/R4 spill other");
        op(0, 1, 0, 0, 0, 0, "R5/R7 fill other");
        op(0, 1, 0, 0, 0, 0, "R5/R6 fill own");
        op(1, 1, 0, 0, 0, 0, "R8 both strobes");
        op(1, 1, 1, 5, 1, 3, "R9 write overrides");
        op(0, 0, 0, 0, 0, 0, "R10 idle");
        op(0, 0, 1, 3, 0, 0, "R11 load max n4");
        op(1, 0, 0, 0, 0, 0, "R11 wrap free n4");
        op(0, 0, 1, 0, 0, 0, "R11 load zeros");
        op(0, 1, 0, 0, 0, 0, "R11 wrap free down");

        for (int i = 0; i < 3000; i++) begin
            t = int'($urandom_range(0, 15));
            w = (t == 0);
            s = (t >= 1 && t <= 6) || t == 15;
            f = (t >= 6 && t <= 11);
            case (tag_of(s, f, w, eo[0]))
                3:  op(s, f, w, int'($urandom_range(0,7)), int'($urandom_range(0,7)), int'($urandom_range(0,7)), "R2/R3 rnd");
                4:  op(s, f, w, 0, 0, 0, "R2/R4 rnd");
                6:  op(s, f, w, 0, 0, 0, "R5/R6 rnd");
                7:  op(s, f, w, 0, 0, 0, "R5/R7 rnd");
                8:  op(s, f, w, 0, 0, 0, "R8 rnd");
                9:  op(s, f, w, int'($urandom_range(0,7)), int'($urandom_range(0,7)), int'($urandom_range(0,3)), "R9 rnd");
                default: op(s, f, w, 0, 0, 0, "R10 rnd");
            endcase
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule